// File: doc/BRIEF.md
# Trigger-Updated Coherent NCO Phase Engine

This block is the phase engine of one numerically controlled oscillator. It holds a 64-bit frequency word, a 16-bit phase offset and a 16-bit signed amplitude. Each of these has two copies: a pending copy that the write strobes fill, and an active copy that the datapath uses. A pending value moves into its active copy only on a load event. A load event is a single-cycle trigger pulse, or a periodic self-resync tick while that option is enabled. On every clock the accumulator advances by the active frequency word. The output frequency is therefore the word times 2^-64 of the sample rate. The word may be read as signed or unsigned.

On a load, the retune mode decides how the accumulator reacts.

- **Continuous mode:** the accumulator runs on from its present value.
- **Coherent mode:** the accumulator is reseeded from a free-running reference count multiplied by the new frequency word. Returning to an earlier frequency therefore restores exactly the phase that frequency would have had if it had never been left.

A clear option zeroes both the accumulator and the reference count on every load. The downstream phase word is the top 16 bits of the accumulator plus the offset shifted up into the top 16 bits, and it is registered. The active settings are presented for readback.

Top module: `nco_coherent_top`

## Requirements
- R1: A synchronous active-high reset clears the pending and active settings, the accumulator, the reference count and `phase_out`. After reset, the reference count rises by one on each clock edge.
- R2: The write strobes change only the pending copies. `freq_live`, `phase_live` and `amp_live`, and the rate of the phase output, keep their values until a load event (trigger or resync tick) copies the pending values across.
- R3: On each edge without a load, the accumulator gains `freq_live` modulo 2^64. `phase_out` is bits 63:48 of (accumulator + offset·2^48), registered one cycle after the accumulator value it reflects. A word of 2^48 steps `phase_out` by exactly 1 per cycle.
- R4: The phase offset adds offset·2^48 to the accumulator before the top 16 bits are taken. One offset LSB equals one `phase_out` LSB (2^-16 of a turn).
- R5: With `cont_mode`=1 and `acc_clr_en`=0, a load leaves the accumulator to advance by the old word on the load edge and by the new word afterwards, with no jump.
- R6: With `cont_mode`=0 and `acc_clr_en`=0, a load sets the accumulator to (reference count after the edge) × new word, modulo 2^64. Retuning A→B→A therefore gives `phase_out` = bits 63:48 of ((n−1)·A) + offset, n edges after reset.
- R7: With `acc_clr_en`=1, every load zeroes both the accumulator and the reference count. Two cycles after the load, `phase_out` equals the offset.
- R8: While `sync_en`=1, a counter started at enable produces a load on the 256th edge after enable, and every 256 edges after that. While `sync_en`=0, no resync occurs.
- R9: A trigger that coincides with a resync tick causes exactly one load, of the same pending values.
- R10: A write in the same cycle as a load lands in the pending copy only. The active copy takes the previous pending value, and the new value waits for the next load.
- R11: The amplitude is a 16-bit two's complement value. `amp_live` returns the active value (for example, 0xFFFB for −5), not the pending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| freq_wr | input | 1 | Write strobe for the pending frequency word |
| freq_wdata | input | 64 | Pending frequency word |
| phase_wr | input | 1 | Write strobe for the pending phase offset |
| phase_wdata | input | 16 | Pending phase offset |
| amp_wr | input | 1 | Write strobe for the pending amplitude |
| amp_wdata | input | 16 | Pending amplitude, two's complement |
| trig | input | 1 | Single-cycle load pulse |
| cont_mode | input | 1 | 1: continuous retune, 0: coherent reseed |
| acc_clr_en | input | 1 | Clear accumulator and reference on each load |
| sync_en | input | 1 | Enable the 256-cycle self-resync |
| phase_out | output | 16 | Registered top phase bits with offset |
| freq_live | output | 64 | Active frequency word |
| phase_live | output | 16 | Active phase offset |
| amp_live | output | 16 | Active amplitude |

## Verification
The assertions watch, on every cycle, the following relations:

- the accumulator step between loads;
- the undisturbed step on a continuous-mode load;
- the reseed value against reference × word on a coherent load;
- the joint clear of accumulator and reference;
- the unit step of the reference count;
- the stability of the active settings while no load source is present.

Only the bench's scenarios can show the rest:

- the exact A→B→A phase return against an independently computed product;
- the 256-edge resync position measured from enable;
- the merge of a coinciding trigger and tick;
- which value wins when a write meets a load.

// File: rtl/nco_pkg.sv
package nco_pkg;

  localparam int FREQ_W_DEF  = 64;
  localparam int PHASE_W_DEF = 16;
  localparam int AMP_W_DEF   = 16;
  localparam int OUT_W_DEF   = 16;
  localparam int SYNC_LOG2   = 8;

  typedef enum logic [1:0] {
    LOAD_IDLE = 2'b00,
    LOAD_TRIG = 2'b01,
    LOAD_SYNC = 2'b10,
    LOAD_BOTH = 2'b11
  } load_cause_e;

  typedef enum logic {
    RETUNE_COHERENT   = 1'b0,
    RETUNE_CONTINUOUS = 1'b1
  } retune_e;

endpackage

// File: rtl/nco_sync_tick.sv
module nco_sync_tick #(
  parameter int PERIOD_LOG2 = nco_pkg::SYNC_LOG2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);

  logic [PERIOD_LOG2-1:0] cnt_q;

  // counter restarts whenever the option is off, so the first tick is a full period after enable
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = en && (cnt_q == {PERIOD_LOG2{1'b1}});

endmodule

// File: rtl/nco_hold_reg.sv
module nco_hold_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         load,
  output logic [W-1:0] pending,
  output logic [W-1:0] active
);

  // pending copy written by software, active copy only on a load event
  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= '0;
      active  <= '0;
    end else begin
      if (wr) begin
        pending <= wdata;
      end
      if (load) begin
        active <= pending;
      end
    end
  end

endmodule

// File: rtl/nco_phase_engine.sv
module nco_phase_engine
  import nco_pkg::*;
#(
  parameter int FREQ_W  = FREQ_W_DEF,
  parameter int PHASE_W = PHASE_W_DEF,
  parameter int OUT_W   = OUT_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  retune_e            mode,
  input  logic               clr_en,
  input  logic [FREQ_W-1:0]  freq_act,
  input  logic [FREQ_W-1:0]  freq_new,
  input  logic [PHASE_W-1:0] phase_act,
  output logic [OUT_W-1:0]   phase_out,
  output logic [FREQ_W-1:0]  acc_mon,
  output logic [FREQ_W-1:0]  ref_mon
);

  localparam int PAD_W = FREQ_W - PHASE_W;

  logic [FREQ_W-1:0] ref_q;
  logic [FREQ_W-1:0] acc_q;
  logic [FREQ_W-1:0] ref_next;
  logic [FREQ_W-1:0] seed;
  logic [FREQ_W-1:0] phase_lj;
  logic [FREQ_W-1:0] phase_sum;

  assign ref_next  = ref_q + 1'b1;
  // coherent seed: the value the accumulator would hold had the new word run since time zero
  assign seed      = ref_next * freq_new;
  assign phase_lj  = {phase_act, {PAD_W{1'b0}}};
  assign phase_sum = acc_q + phase_lj;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q     <= '0;
      acc_q     <= '0;
      phase_out <= '0;
    end else begin
      phase_out <= phase_sum[FREQ_W-1 -: OUT_W];
      if (load && clr_en) begin
        ref_q <= '0;
        acc_q <= '0;
      end else begin
        ref_q <= ref_next;
        if (load && (mode == RETUNE_COHERENT)) begin
          acc_q <= seed;
        end else begin
          acc_q <= acc_q + freq_act;
        end
      end
    end
  end

  assign acc_mon = acc_q;
  assign ref_mon = ref_q;

endmodule

// File: rtl/nco_coherent_top.sv
module nco_coherent_top
  import nco_pkg::*;
#(
  parameter int FREQ_W    = FREQ_W_DEF,
  parameter int PHASE_W   = PHASE_W_DEF,
  parameter int AMP_W     = AMP_W_DEF,
  parameter int OUT_W     = OUT_W_DEF,
  parameter int SYNC_BITS = SYNC_LOG2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               freq_wr,
  input  logic [FREQ_W-1:0]  freq_wdata,
  input  logic               phase_wr,
  input  logic [PHASE_W-1:0] phase_wdata,
  input  logic               amp_wr,
  input  logic [AMP_W-1:0]   amp_wdata,
  input  logic               trig,
  input  logic               cont_mode,
  input  logic               acc_clr_en,
  input  logic               sync_en,
  output logic [OUT_W-1:0]   phase_out,
  output logic [FREQ_W-1:0]  freq_live,
  output logic [PHASE_W-1:0] phase_live,
  output logic [AMP_W-1:0]   amp_live
);

  logic              sync_tick;
  load_cause_e       cause;
  logic              load_now;
  retune_e           mode;
  logic [FREQ_W-1:0] freq_pend;
  logic [PHASE_W-1:0] phase_pend;
  logic [AMP_W-1:0]  amp_pend;
  logic [FREQ_W-1:0] acc_now;
  logic [FREQ_W-1:0] ref_now;

  nco_sync_tick #(.PERIOD_LOG2(SYNC_BITS)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .en   (sync_en),
    .tick (sync_tick)
  );

  // trigger and tick merge into a single load
  assign cause    = load_cause_e'({sync_tick, trig});
  assign load_now = (cause != LOAD_IDLE);
  assign mode     = retune_e'(cont_mode);

  nco_hold_reg #(.W(FREQ_W)) u_freq (
    .clk (clk), .rst (rst), .wr (freq_wr), .wdata (freq_wdata),
    .load (load_now), .pending (freq_pend), .active (freq_live)
  );

  nco_hold_reg #(.W(PHASE_W)) u_phase (
    .clk (clk), .rst (rst), .wr (phase_wr), .wdata (phase_wdata),
    .load (load_now), .pending (phase_pend), .active (phase_live)
  );

  nco_hold_reg #(.W(AMP_W)) u_amp (
    .clk (clk), .rst (rst), .wr (amp_wr), .wdata (amp_wdata),
    .load (load_now), .pending (amp_pend), .active (amp_live)
  );

  nco_phase_engine #(
    .FREQ_W  (FREQ_W),
    .PHASE_W (PHASE_W),
    .OUT_W   (OUT_W)
  ) u_eng (
    .clk       (clk),
    .rst       (rst),
    .load      (load_now),
    .mode      (mode),
    .clr_en    (acc_clr_en),
    .freq_act  (freq_live),
    .freq_new  (freq_pend),
    .phase_act (phase_live),
    .phase_out (phase_out),
    .acc_mon   (acc_now),
    .ref_mon   (ref_now)
  );

endmodule

// File: rtl/nco_coherent_top_chk.sv
module nco_coherent_top_chk #(
  parameter int FREQ_W  = 64,
  parameter int PHASE_W = 16,
  parameter int AMP_W   = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               trig,
  input logic               sync_en,
  input logic               cont_mode,
  input logic               acc_clr_en,
  input logic               load_now,
  input logic [FREQ_W-1:0]  acc_now,
  input logic [FREQ_W-1:0]  ref_now,
  input logic [FREQ_W-1:0]  freq_live,
  input logic [PHASE_W-1:0] phase_live,
  input logic [AMP_W-1:0]   amp_live
);

  // R2
  settings_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!trig && !sync_en) |=> ($stable(freq_live) && $stable(phase_live) && $stable(amp_live)));

  // R3
  acc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !load_now |=> (acc_now == $past(acc_now) + $past(freq_live)));

  // R5
  cont_retune_chk: assert property (@(posedge clk) disable iff (rst)
    (load_now && cont_mode && !acc_clr_en) |=> (acc_now == $past(acc_now) + $past(freq_live)));

  // R6
  coherent_seed_chk: assert property (@(posedge clk) disable iff (rst)
    (load_now && !cont_mode && !acc_clr_en) |=> (acc_now == ref_now * freq_live));

  // R7
  load_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (load_now && acc_clr_en) |=> (acc_now == '0 && ref_now == '0));

  // R1
  ref_count_chk: assert property (@(posedge clk) disable iff (rst)
    !(load_now && acc_clr_en) |=> (ref_now == $past(ref_now) + 1'b1));

endmodule

bind nco_coherent_top nco_coherent_top_chk #(
  .FREQ_W  (FREQ_W),
  .PHASE_W (PHASE_W),
  .AMP_W   (AMP_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .trig       (trig),
  .sync_en    (sync_en),
  .cont_mode  (cont_mode),
  .acc_clr_en (acc_clr_en),
  .load_now   (load_now),
  .acc_now    (acc_now),
  .ref_now    (ref_now),
  .freq_live  (freq_live),
  .phase_live (phase_live),
  .amp_live   (amp_live)
);

// File: tb/nco_coherent_top_bench.sv
`timescale 1ns/1ps
module nco_coherent_top_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        freq_wr = 1'b0;
  logic [63:0] freq_wdata = '0;
  logic        phase_wr = 1'b0;
  logic [15:0] phase_wdata = '0;
  logic        amp_wr = 1'b0;
  logic [15:0] amp_wdata = '0;
  logic        trig = 1'b0;
  logic        cont_mode = 1'b1;
  logic        acc_clr_en = 1'b0;
  logic        sync_en = 1'b0;
  logic [15:0] phase_out;
  logic [63:0] freq_live;
  logic [15:0] phase_live;
  logic [15:0] amp_live;

  int vectors = 0;
  int miscompares = 0;
  logic [63:0] edges = '0;

  always #5 clk = ~clk;

  nco_coherent_top u_nco_coherent_top (
    .clk (clk), .rst (rst),
    .freq_wr (freq_wr), .freq_wdata (freq_wdata),
    .phase_wr (phase_wr), .phase_wdata (phase_wdata),
    .amp_wr (amp_wr), .amp_wdata (amp_wdata),
    .trig (trig), .cont_mode (cont_mode), .acc_clr_en (acc_clr_en),
    .sync_en (sync_en), .phase_out (phase_out), .freq_live (freq_live),
    .phase_live (phase_live), .amp_live (amp_live)
  );

  // behavioural expectation built from the requirements
  logic [63:0] m_ref, m_acc, m_fp, m_fa, m_sum;
  logic [15:0] m_pp, m_pa, m_ap, m_aa, m_out;
  logic [7:0]  m_sync;
  logic        m_ld;

  always @(posedge clk) begin
    if (rst) begin
      edges = '0;
      m_ref = '0; m_acc = '0; m_fp = '0; m_fa = '0;
      m_pp = '0; m_pa = '0; m_ap = '0; m_aa = '0; m_out = '0; m_sync = '0;
    end else begin
      edges = edges + 1;
      m_ld  = trig || (sync_en && m_sync == 8'hFF);
      m_sum = m_acc + {m_pa, 48'h0};
      m_out = m_sum[63:48];
      if (m_ld && acc_clr_en) begin
        m_acc = '0; m_ref = '0;
      end else begin
        if (m_ld && !cont_mode) m_acc = (m_ref + 64'd1) * m_fp;
        else                    m_acc = m_acc + m_fa;
        m_ref = m_ref + 64'd1;
      end
      m_sync = sync_en ? m_sync + 8'd1 : 8'd0;
      if (m_ld) begin
        m_fa = m_fp; m_pa = m_pp; m_aa = m_ap;
      end
      if (freq_wr)  m_fp = freq_wdata;
      if (phase_wr) m_pp = phase_wdata;
      if (amp_wr)   m_ap = amp_wdata;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic model_cmp(input string tag);
    chk({tag, " phase_out"}, {48'h0, phase_out}, {48'h0, m_out});
    chk({tag, " freq_live"}, freq_live, m_fa);
    chk({tag, " phase_live"}, {48'h0, phase_live}, {48'h0, m_pa});
    chk({tag, " amp_live"}, {48'h0, amp_live}, {48'h0, m_aa});
  endtask

  task automatic pulse_trig();
    trig = 1'b1; adv(1); trig = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; adv(3); rst = 1'b0;
    chk("R1 reset phase_out", {48'h0, phase_out}, 64'h0);
    chk("R1 reset freq_live", freq_live, 64'h0);
    chk("R1 reset amp_live", {48'h0, amp_live}, 64'h0);
    adv(5);
    chk("R1 idle phase_out", {48'h0, phase_out}, 64'h0);
  endtask

  task automatic t_pending();
    freq_wr = 1'b1; freq_wdata = 64'h0001_0000_0000_0000;
    phase_wr = 1'b1; phase_wdata = 16'd5;
    adv(1); freq_wr = 1'b0; phase_wr = 1'b0;
    adv(4);
    chk("R2 pending freq_live", freq_live, 64'h0);
    chk("R2 pending phase_live", {48'h0, phase_live}, 64'h0);
    chk("R2 pending phase_out", {48'h0, phase_out}, 64'h0);
    pulse_trig();
    chk("R2 loaded freq_live", freq_live, 64'h0001_0000_0000_0000);
    chk("R2 loaded phase_live", {48'h0, phase_live}, 64'd5);
  endtask

  task automatic t_advance();
    logic [15:0] p0;
    adv(2);
    p0 = phase_out;
    adv(1);
    chk("R3 unit step", {48'h0, phase_out}, {48'h0, p0 + 16'd1});
    model_cmp("R3 advance");
    // acc = k units since load; offset 5 adds 5 LSBs
    chk("R4 offset in output", {48'h0, phase_out}, {48'h0, m_out});
    chk("R4 offset vs count", {48'h0, phase_out - phase_live}, {48'h0, p0 - 16'd4});
  endtask

  task automatic t_continuous();
    logic [15:0] pa, pb;
    freq_wr = 1'b1; freq_wdata = 64'h0003_0000_0000_0000;
    adv(1); freq_wr = 1'b0;
    pa = phase_out;
    pulse_trig();
    adv(2);
    // reflects acc after load edge (+1) and one more edge (+3) -> pa +1 +1 +3
    chk("R5 no jump", {48'h0, phase_out}, {48'h0, pa + 16'd5});
    pb = phase_out;
    adv(1);
    chk("R5 new rate", {48'h0, phase_out}, {48'h0, pb + 16'd3});
    model_cmp("R5 continuous");
  endtask

  task automatic t_coherent();
    logic [63:0] a, b, prod;
    a = 64'h0123_4567_89AB_CDEF;
    b = 64'h7777_0000_1234_5555;
    cont_mode = 1'b0;
    freq_wr = 1'b1; freq_wdata = a; adv(1); freq_wr = 1'b0;
    pulse_trig(); adv(20);
    freq_wr = 1'b1; freq_wdata = b; adv(1); freq_wr = 1'b0;
    pulse_trig(); adv(37);
    model_cmp("R6 at B");
    freq_wr = 1'b1; freq_wdata = a; adv(1); freq_wr = 1'b0;
    pulse_trig(); adv(10);
    prod = (edges - 64'd1) * a;
    chk("R6 phase restored", {48'h0, phase_out}, {48'h0, prod[63:48] + 16'd5});
    model_cmp("R6 back at A");
  endtask

  task automatic t_write_on_load();
    amp_wr = 1'b1; amp_wdata = 16'hFFFB; trig = 1'b1;
    adv(1); amp_wr = 1'b0; trig = 1'b0;
    chk("R10 old pending taken", {48'h0, amp_live}, 64'h0);
    adv(3);
    chk("R10 still pending", {48'h0, amp_live}, 64'h0);
    pulse_trig();
    chk("R11 signed amp readback", {48'h0, amp_live}, 64'h0000_0000_0000_FFFB);
    model_cmp("R11 after load");
  endtask

  task automatic t_clear();
    acc_clr_en = 1'b1;
    pulse_trig(); acc_clr_en = 1'b0;
    adv(1);
    chk("R7 cleared phase_out", {48'h0, phase_out}, 64'd5);
    model_cmp("R7 after clear");
  endtask

  task automatic t_sync();
    freq_wr = 1'b1; freq_wdata = 64'h0000_4000_0000_0000; adv(1); freq_wr = 1'b0;
    sync_en = 1'b1;
    adv(255);
    chk("R8 not yet at 255", freq_live, 64'h0123_4567_89AB_CDEF);
    adv(1);
    chk("R8 resync at 256", freq_live, 64'h0000_4000_0000_0000);
    freq_wr = 1'b1; freq_wdata = 64'h0000_0800_0000_0000; adv(1); freq_wr = 1'b0;
    adv(254);
    trig = 1'b1; adv(1); trig = 1'b0;
    chk("R9 coincident load", freq_live, 64'h0000_0800_0000_0000);
    adv(3);
    model_cmp("R9 coincident");
    sync_en = 1'b0;
    freq_wr = 1'b1; freq_wdata = 64'h1111_0000_0000_0000; adv(1); freq_wr = 1'b0;
    adv(300);
    chk("R8 disabled no resync", freq_live, 64'h0000_0800_0000_0000);
    model_cmp("R8 disabled");
  endtask

  initial begin
    #2_000_000;
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_pending();
    t_advance();
    t_continuous();
    t_coherent();
    t_write_on_load();
    t_clear();
    t_sync();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule